// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 interrupt sources into one interrupt line for a processor. Each source sets a bit in a status register. An elaboration-time parameter fixes whether a source is level-sensitive or edge-sensitive. A level source's status bit follows the input. An edge source's status bit is set on a rising input and stays set until software removes it.

The status register is masked by an enable register to form the pending register. The block also reports the index of the lowest pending source, and drives a registered interrupt output.

Software reaches the block through a simple synchronous word-addressed bus. Reads are combinational and writes take effect at the clock edge. Besides plain writes to status, enable and the master control word, three write-only offsets act on existing registers:
- one clears status bits (acknowledge);
- one ORs bits into the enable register;
- one removes bits from the enable register.

The two-bit master control word has separate bits for the interrupt output and for sampling of the source inputs.

Top module: `irq_aggregator`

## Requirements
- R1: Word offsets are decoded as 0 status, 1 pending, 2 enable, 3 acknowledge, 4 enable-set, 5 enable-clear, 6 vector, 7 master control. Any other offset reads zero and ignores writes. Offsets 3, 4 and 5 read zero. Writes to offsets 1 and 6 have no effect.
- R2: Pending always reads as status AND enable.
- R3: Writing to offset 3 clears every status bit that is 1 in the written word. A plain write to offset 0 stores the word into status.
- R4: Writing to offset 4 ORs the word into enable. Writing to offset 5 clears the enable bits that are 1 in the word. Writing to offset 2 stores the word into enable.
- R5: The vector (offset 6) reads the index of the lowest set pending bit, or 0xFFFFFFFF when nothing is pending.
- R6: One cycle after an edge, irq_out is 1 exactly when master bit 0 and the pending register are both nonzero after that edge, except as stated in R8.
- R7: While master bit 1 is 0, the source inputs do not change status. Register writes still do.
- R8: If master bit 1 is 0 and any source input differs from its value at the previous edge, irq_out is 0 for the following cycle.
- R9: While master bit 1 is 1, a level source (EDGE_SEL bit 0) has its status bit follow its input at each edge, both setting and clearing.
- R10: While master bit 1 is 1, an edge source (EDGE_SEL bit 1) sets its status bit when its input rises. A low input never clears it. A rise in the same cycle as an acknowledge of that bit leaves the bit set.
- R11: Master control (offset 7) stores bits 1:0 of the written word, and its upper bits read zero.
- R12: After reset, all registers read zero except the vector, which reads 0xFFFFFFFF, and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_in | input | NSRC | Interrupt source inputs |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The hardest case to reach is a rising edge on an edge-sensitive source in the same cycle as an acknowledge of that bit. The stimulus has to drop the input, let one edge pass, then raise it while writing the acknowledge. A directed sequence builds this case, and random stimulus, with acknowledge writes common, hits it often.

Output blanking needs sampling disabled while the inputs move, so random cycles toggle the master word and the inputs together. The bench model predicts irq_out on every cycle and compares it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_EN     = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VEC    = 3'd6,
    OFS_MASTER = 3'd7
  } reg_ofs_e;

  // lowest set bit index, all ones when the word is zero
  function automatic logic [DW-1:0] first_index(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = '1;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) r = DW'(i);
    end
    return r;
  endfunction

  // status bit next value from its sources, set has the last word
  function automatic logic capture_bit(input logic cur, input logic wr_val,
                                       input logic do_wr, input logic do_ack,
                                       input logic sample, input logic is_edge,
                                       input logic lvl, input logic rise);
    logic b;
    b = do_wr ? wr_val : cur;
    if (do_ack) b = 1'b0;
    if (sample) begin
      if (is_edge) b = b | rise;
      else         b = lvl;
    end
    return b;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output reg_ofs_e          ofs,
  output logic              wr_status,
  output logic              wr_ack,
  output logic              wr_en,
  output logic              wr_seten,
  output logic              wr_clren,
  output logic              wr_master
);
  localparam int unsigned OW = 3;

  generate
    if (ADDR_W > OW) begin : g_wide
      assign hit = (addr[ADDR_W-1:OW] == '0);
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign ofs = reg_ofs_e'(addr[OW-1:0]);

  always_comb begin
    wr_status = 1'b0;
    wr_ack    = 1'b0;
    wr_en     = 1'b0;
    wr_seten  = 1'b0;
    wr_clren  = 1'b0;
    wr_master = 1'b0;
    if (wr && hit) begin
      unique case (ofs)
        OFS_STATUS: wr_status = 1'b1;
        OFS_ACK:    wr_ack    = 1'b1;
        OFS_EN:     wr_en     = 1'b1;
        OFS_SETEN:  wr_seten  = 1'b1;
        OFS_CLREN:  wr_clren  = 1'b1;
        OFS_MASTER: wr_master = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  input  logic            wr_seten,
  input  logic            wr_clren,
  input  logic            wr_master,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] en_d,
  output logic [1:0]      master_q,
  output logic [1:0]      master_d
);
  always_comb begin
    en_d = en_q;
    if (wr_en)    en_d = wdata[NSRC-1:0];
    if (wr_seten) en_d = en_q | wdata[NSRC-1:0];
    if (wr_clren) en_d = en_q & ~wdata[NSRC-1:0];
    master_d = wr_master ? wdata[1:0] : master_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      master_q <= '0;
    end else begin
      en_q     <= en_d;
      master_q <= master_d;
    end
  end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture
  import irqc_pkg::*;
#(
  parameter int unsigned     NSRC     = 32,
  parameter logic [NSRC-1:0] EDGE_SEL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            sample,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_status,
  input  logic            wr_ack,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] status_d,
  output logic [NSRC-1:0] src_prev,
  output logic [NSRC-1:0] src_rise,
  output logic            src_moved
);
  assign src_moved = |(src_in ^ src_prev);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (EDGE_SEL[i]) begin : g_edge
        assign src_rise[i] = src_in[i] & ~src_prev[i];
      end else begin : g_level
        assign src_rise[i] = 1'b0;
      end

      assign status_d[i] = capture_bit(status_q[i], wdata[i], wr_status,
                                       wr_ack & wdata[i], sample, EDGE_SEL[i],
                                       src_in[i], src_rise[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          status_q[i] <= 1'b0;
          src_prev[i] <= 1'b0;
        end else begin
          status_q[i] <= status_d[i];
          src_prev[i] <= src_in[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irqc_output.sv
module irqc_output
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] status_d,
  input  logic [NSRC-1:0] en_d,
  input  logic [1:0]      master_d,
  input  logic            blank,
  output logic [DW-1:0]   pend_w,
  output logic [DW-1:0]   vec_w,
  output logic            irq_q
);
  logic [DW-1:0] pend_next;

  assign pend_w    = DW'(status_q & en_q);
  assign vec_w     = first_index(pend_w);
  assign pend_next = DW'(status_d & en_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= !blank && master_d[0] && (pend_next != '0);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqc_pkg::*;
#(
  parameter int unsigned     NSRC     = 32,
  parameter int unsigned     ADDR_W   = 4,
  parameter logic [NSRC-1:0] EDGE_SEL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out
);
  logic            hit;
  reg_ofs_e        ofs;
  logic            wr_status, wr_ack, wr_en, wr_seten, wr_clren, wr_master;
  logic [NSRC-1:0] en_q, en_d, status_q, status_d, src_prev, src_rise;
  logic [1:0]      master_q, master_d;
  logic            src_moved, sample, blank;
  logic [DW-1:0]   pend_w, vec_w;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit(hit), .ofs(ofs),
    .wr_status(wr_status), .wr_ack(wr_ack), .wr_en(wr_en),
    .wr_seten(wr_seten), .wr_clren(wr_clren), .wr_master(wr_master)
  );

  irqc_ctrl_regs #(.NSRC(NSRC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .wr_en(wr_en), .wr_seten(wr_seten), .wr_clren(wr_clren),
    .wr_master(wr_master), .en_q(en_q), .en_d(en_d),
    .master_q(master_q), .master_d(master_d)
  );

  assign sample = master_q[1];
  assign blank  = !sample && src_moved;

  irqc_capture #(.NSRC(NSRC), .EDGE_SEL(EDGE_SEL)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sample(sample),
    .wdata(bus_wdata), .wr_status(wr_status), .wr_ack(wr_ack),
    .status_q(status_q), .status_d(status_d), .src_prev(src_prev),
    .src_rise(src_rise), .src_moved(src_moved)
  );

  irqc_output #(.NSRC(NSRC)) u_out (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .en_q(en_q),
    .status_d(status_d), .en_d(en_d), .master_d(master_d), .blank(blank),
    .pend_w(pend_w), .vec_w(vec_w), .irq_q(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (ofs)
        OFS_STATUS: bus_rdata = DW'(status_q);
        OFS_PEND:   bus_rdata = pend_w;
        OFS_EN:     bus_rdata = DW'(en_q);
        OFS_VEC:    bus_rdata = vec_w;
        OFS_MASTER: bus_rdata = DW'(master_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned     NSRC     = 32,
  parameter int unsigned     ADDR_W   = 4,
  parameter logic [NSRC-1:0] EDGE_SEL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [NSRC-1:0]   src_in,
  input logic              irq_out,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   en_q,
  input logic [1:0]        master_q,
  input logic [NSRC-1:0]   src_prev,
  input logic [NSRC-1:0]   src_rise,
  input logic [31:0]       pend_w,
  input logic [31:0]       vec_w
);
  logic [NSRC-1:0] wmask;
  logic            ack_hit, seten_hit, clren_hit, stat_hit;

  assign wmask     = bus_wdata[NSRC-1:0];
  assign ack_hit   = bus_wr && (bus_addr == ADDR_W'(3));
  assign seten_hit = bus_wr && (bus_addr == ADDR_W'(4));
  assign clren_hit = bus_wr && (bus_addr == ADDR_W'(5));
  assign stat_hit  = bus_wr && (bus_addr == ADDR_W'(0));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !master_q[1]) |=> ((status_q & $past(wmask)) == '0));

  a_r4_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    seten_hit |=> ((en_q & $past(wmask)) == $past(wmask)));

  a_r4_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
    clren_hit |=> ((en_q & $past(wmask)) == '0));

  a_r5_vector_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w == '0) == (vec_w == 32'hFFFF_FFFF));

  a_r5_vector_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w != '0) |-> (pend_w[vec_w[4:0]] && ((pend_w & ((32'd1 << vec_w[4:0]) - 32'd1)) == '0)));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master_q[0] && ((status_q & en_q) != '0)));

  a_r7_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q[1] && !ack_hit && !stat_hit) |=> $stable(status_q));

  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q[1] && (src_in != src_prev)) |=> !irq_out);

  a_r9_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    master_q[1] |=> ((status_q & ~EDGE_SEL) == ($past(src_in) & ~EDGE_SEL)));

  a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    master_q[1] |=> ((status_q & $past(src_rise)) == $past(src_rise)));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .EDGE_SEL(EDGE_SEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .src_in(src_in), .irq_out(irq_out),
  .status_q(status_q), .en_q(en_q), .master_q(master_q),
  .src_prev(src_prev), .src_rise(src_rise), .pend_w(pend_w), .vec_w(vec_w)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam logic [31:0] EDGE = 32'hA5A5_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_st, m_en, m_prev;
  logic [1:0]  m_ms;
  logic        m_irq;

  always #2 clk = ~clk;

  irq_aggregator #(.NSRC(32), .ADDR_W(4), .EDGE_SEL(EDGE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] low_idx(input logic [31:0] p);
    for (int k = 0; k < 32; k++) if (p[k]) return 32'(k);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] p;
    p = m_st & m_en;
    case (a)
      4'd0: return m_st;
      4'd1: return p;
      4'd2: return m_en;
      4'd6: return low_idx(p);
      4'd7: return {30'd0, m_ms};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d,
                            input logic [31:0] s);
    logic [31:0] st, en, rise;
    logic [1:0] ms;
    logic hw;
    hw = m_ms[1];
    rise = s & ~m_prev;
    st = m_st; en = m_en; ms = m_ms;
    if (w) begin
      case (a)
        4'd0: st = d;
        4'd2: en = d;
        4'd3: st = st & ~d;
        4'd4: en = en | d;
        4'd5: en = en & ~d;
        4'd7: ms = d[1:0];
        default: ;
      endcase
    end
    if (hw) st = (st & EDGE) | (s & ~EDGE) | (rise & EDGE);
    m_irq = (!hw && (s != m_prev)) ? 1'b0 : (ms[0] && ((st & en) != 0));
    m_st = st; m_en = en; m_ms = ms; m_prev = s;
  endtask

  // drive one cycle at negedge, model the edge, check irq_out at next negedge
  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] s);
    bus_wr = w; bus_addr = a; bus_wdata = d; src_in = s;
    @(posedge clk);
    model_step(w, a, d, s);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R6 R8 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
  endtask

  task automatic peek(input string tag, input logic [3:0] a);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic peek_all(input string tag);
    for (int a = 0; a < 9; a++) peek(tag, 4'(a));
  endtask

  initial begin
    #700000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd20240611));
    m_st = 0; m_en = 0; m_prev = 0; m_ms = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 irq after reset", {31'd0, irq_out}, 32'd0);
    peek("R12 vector after reset", 4'd6);
    chk("R12 vector all ones", bus_rdata, 32'hFFFF_FFFF);
    peek_all("R12 reset reads");

    // R11 master stores two bits
    cyc(1, 4'd7, 32'hFFFF_FFFF, 0);
    peek("R11 master width", 4'd7);
    chk("R11 master reads 3", bus_rdata, 32'd3);
    cyc(1, 4'd4, 32'h0000_00F3, 0);
    peek("R4 set-enable", 4'd2);
    // R9 level source bit 4
    cyc(0, 4'd0, 0, 32'h10);
    peek("R9 level sets", 4'd0);
    chk("R9 status bit4", bus_rdata, 32'h10);
    chk("R6 irq on level", {31'd0, irq_out}, 32'd1);
    cyc(0, 4'd0, 0, 32'h30);
    peek("R5 vector lowest", 4'd6);
    chk("R5 vector is 4", bus_rdata, 32'd4);
    cyc(0, 4'd0, 0, 32'h0);
    peek("R9 level clears", 4'd0);
    chk("R9 status zero", bus_rdata, 32'd0);
    peek("R5 vector empty", 4'd6);
    chk("R5 vector none", bus_rdata, 32'hFFFF_FFFF);

    // R10 edge source bit 0
    cyc(0, 4'd0, 0, 32'h1);
    cyc(0, 4'd0, 0, 32'h0);
    peek("R10 edge sticks", 4'd0);
    chk("R10 bit0 held", bus_rdata, 32'h1);
    cyc(1, 4'd3, 32'h1, 32'h0);
    peek("R3 ack clears", 4'd0);
    chk("R3 bit0 gone", bus_rdata, 32'h0);
    cyc(1, 4'd3, 32'h1, 32'h1);
    peek("R10 set beats ack", 4'd0);
    chk("R10 bit0 survives", bus_rdata, 32'h1);
    cyc(1, 4'd3, 32'h1, 32'h1);
    peek("R10 held high no rise", 4'd0);
    chk("R10 ack with no rise", bus_rdata, 32'h0);

    // R4 clear-enable, R2 pending
    cyc(1, 4'd0, 32'h0000_0003, 32'h1);
    cyc(1, 4'd5, 32'h0000_0001, 32'h1);
    peek("R2 pending masked", 4'd1);
    chk("R2 pending bit1", bus_rdata, 32'h2);
    cyc(1, 4'd2, 32'h8000_0000, 32'h1);
    peek("R4 plain enable write", 4'd2);

    // R1 ignored writes
    cyc(1, 4'd9, 32'hFFFF_FFFF, 32'h1);
    cyc(1, 4'd1, 32'hFFFF_FFFF, 32'h1);
    cyc(1, 4'd6, 32'h0, 32'h1);
    peek_all("R1 ignored writes");
    peek("R1 undecoded read", 4'd12);
    chk("R1 offset 12 zero", bus_rdata, 32'd0);

    // R7 R8 sampling off
    cyc(1, 4'd0, 32'h8000_0000, 32'h1);
    cyc(1, 4'd7, 32'h1, 32'h1);
    cyc(0, 4'd0, 0, 32'h10);
    chk("R8 blank on change", {31'd0, irq_out}, 32'd0);
    peek("R7 status frozen", 4'd0);
    chk("R7 status unchanged", bus_rdata, 32'h8000_0000);
    cyc(0, 4'd0, 0, 32'h10);
    chk("R6 irq back", {31'd0, irq_out}, 32'd1);

    // random
    for (int n = 0; n < 6000; n++) begin
      logic [3:0] a;
      logic [31:0] d;
      logic w;
      int r;
      r = int'($urandom % 100);
      s = src_in;
      if (r < 40) s = s ^ (32'd1 << ($urandom % 32));
      if (r < 8) s = $urandom;
      w = ($urandom % 3) != 0;
      a = 4'($urandom % 10);
      d = $urandom;
      if (($urandom % 4) == 0) d = 32'd1 << ($urandom % 32);
      if (a == 4'd7 && ($urandom % 2) == 0) d = 32'd2 | ($urandom % 2);
      cyc(w, a, d, s);
      peek("R1 R2 R5 random read", 4'($urandom % 10));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule